// File: doc/BRIEF.md
# Snapshot Interface Paging Controller

This block is the control logic of a snapshot peripheral that sits on a Z80-style bus. It watches the memory and I/O strobes, the address and the data bus, and a freeze push-button. From these it raises a non-maskable interrupt request, and it overlays an 8 KB ROM and an 8 KB RAM on the lowest 16 KB of the address space. It holds four state bits: overlay paged in, interrupt pending, device hidden, and host all-RAM mode.

A press of the button requests the interrupt. The CPU's opcode fetch of the interrupt vector at 0x0066 then pages the overlay in, so the snapshot code gains control. Software uses a control port to page the overlay in or out, to re-arm the button and to hide the device. When the host memory unit is switched into all-RAM mode, the overlay cannot work, so a write of that mode bit mutes the device.

All bus inputs are sampled in the controller's clock domain. The button is asynchronous. Each bus access changes state only once, on the first clock edge at which its strobe combination is present.

Top module: `snap_pager_top`

## Requirements
- R1: After reset, nmi_n is 1, both chip enables are 1, the overlay is paged out, the pending and all-RAM flags are 0 and the device is hidden.
- R2: rom_ce_n is 0 exactly when the overlay is paged in, mreq_n is 0 and addr[15:13] is 000. If mreq_n is 1, neither enable is 0.
- R3: ram_ce_n is 0 exactly when the overlay is paged in, mreq_n is 0 and addr[15:13] is 001.
- R4: An opcode fetch (mreq_n, rd_n and m1_n all 0) at address 0x0066 pages the overlay in, but only while the pending flag is 1 and the all-RAM flag is 0. Otherwise it does not change the paging.
- R5: An I/O read (iorq_n and rd_n 0) with addr[6:0] equal to 0111111 works as follows. When the device is not hidden, it pages the overlay in if addr[7] is 0 and pages it out if addr[7] is 1. When the device is hidden, it pages the overlay out.
- R6: An I/O write (iorq_n and wr_n 0) with addr[6:0] equal to 0111111 clears the pending flag. If addr[7:0] is 0x3F, the same write also hides the device. The write does not change the paging.
- R7: An I/O write with addr[15:12] equal to 0001 and addr[7:0] equal to 0xFD loads data[0] into the all-RAM flag. Other upper nibbles, such as 0111, leave the flag unchanged.
- R8: A button press sets the pending flag and clears hidden, but only while the pending flag is 0 and the all-RAM flag is 0. Otherwise the press is ignored.
- R9: nmi_n is 0 exactly while the pending flag is 1 and the all-RAM flag is 0.
- R10: The button passes through a two-flop synchronizer and a rising-edge detector. A press held for many cycles produces exactly one event.
- R11: A bus access whose strobes are held over several clocks acts only on the first of them. Address changes later in the same access have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mreq_n | input | 1 | Memory request strobe, active low |
| iorq_n | input | 1 | I/O request strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| m1_n | input | 1 | Opcode fetch cycle marker, active low |
| addr | input | 16 | CPU address bus |
| data | input | 8 | CPU data bus, as written by the CPU |
| button | input | 1 | Freeze push-button, asynchronous, active high |
| nmi_n | output | 1 | Non-maskable interrupt request, active low |
| rom_ce_n | output | 1 | Overlay ROM chip enable, active low |
| ram_ce_n | output | 1 | Overlay RAM chip enable, active low |

## Verification
Assertions check on every cycle the following rules:
- the two chip enables are never active together, and neither is active without a memory request;
- an all-RAM host never sees the interrupt;
- a decoded event never repeats on the cycle after it fires;
- each event has its effect on the next state: hide, clear pending, load the mode bit, page in on the vector fetch, page out while hidden;
- the pending flag rises only after a button event.

Only the bench's scenarios can show the orderings. These are the pressing sequence that leads through the vector fetch, the port reads that page in and out, the mode write that mutes and then restores the interrupt, a press ignored under all-RAM, a held strobe whose address moves mid-access, and a long button hold.

// File: rtl/snap_pkg.sv
package snap_pkg;

  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;

  localparam logic [6:0]  CTL_LOW7   = 7'h3F;
  localparam logic [7:0]  HIDE_LOW8  = 8'h3F;
  localparam logic [7:0]  MODE_LOW8  = 8'hFD;
  localparam logic [3:0]  MODE_HIGH4 = 4'b0001;
  localparam logic [15:0] NMI_VECTOR = 16'h0066;

  typedef struct packed {
    logic fetch_vec;
    logic ctl_rd;
    logic ctl_wr;
    logic hide_wr;
    logic mode_wr;
  } bus_ev_t;

  function automatic logic is_ctl_port(input logic [ADDR_W-1:0] a);
    return a[6:0] == CTL_LOW7;
  endfunction

  function automatic logic is_hide_port(input logic [ADDR_W-1:0] a);
    return a[7:0] == HIDE_LOW8;
  endfunction

  function automatic logic is_mode_port(input logic [ADDR_W-1:0] a);
    return (a[15:12] == MODE_HIGH4) && (a[7:0] == MODE_LOW8);
  endfunction

  function automatic logic is_vector(input logic [ADDR_W-1:0] a);
    return a == NMI_VECTOR;
  endfunction

  // sel picks the 8 KB window: 0 = ROM, 1 = RAM
  function automatic logic in_window(input logic [ADDR_W-1:0] a, input logic sel);
    return a[15:13] == {2'b00, sel};
  endfunction

endpackage

// File: rtl/snap_btn_sync.sv
module snap_btn_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic btn_i,
  output logic press_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], btn_i};
      last_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign press_o = sync_q[SYNC_STAGES-1] & ~last_q;

  // R10: one event per press
  a_r10_single_press: assert property (@(posedge clk) disable iff (!rst_n)
    press_o |=> !press_o);

endmodule

// File: rtl/snap_bus_decode.sv
module snap_bus_decode
  import snap_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mreq_n,
  input  logic              iorq_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic              m1_n,
  input  logic [ADDR_W-1:0] addr,
  output bus_ev_t           ev_o,
  output logic              a7_o
);
  logic io_rd_act, io_wr_act, fetch_act;
  logic io_rd_q, io_wr_q, fetch_q;
  logic io_rd_first, io_wr_first, fetch_first;

  assign io_rd_act = ~iorq_n & ~rd_n;
  assign io_wr_act = ~iorq_n & ~wr_n;
  assign fetch_act = ~mreq_n & ~rd_n & ~m1_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      io_rd_q <= 1'b0;
      io_wr_q <= 1'b0;
      fetch_q <= 1'b0;
    end else begin
      io_rd_q <= io_rd_act;
      io_wr_q <= io_wr_act;
      fetch_q <= fetch_act;
    end
  end

  assign io_rd_first = io_rd_act & ~io_rd_q;
  assign io_wr_first = io_wr_act & ~io_wr_q;
  assign fetch_first = fetch_act & ~fetch_q;

  always_comb begin
    ev_o.fetch_vec = fetch_first & is_vector(addr);
    ev_o.ctl_rd    = io_rd_first & is_ctl_port(addr);
    ev_o.ctl_wr    = io_wr_first & is_ctl_port(addr);
    ev_o.hide_wr   = io_wr_first & is_hide_port(addr);
    ev_o.mode_wr   = io_wr_first & is_mode_port(addr);
  end

  assign a7_o = addr[7];

  // R11: a held access yields a single event
  a_r11_rd_once: assert property (@(posedge clk) disable iff (!rst_n)
    ev_o.ctl_rd |=> !ev_o.ctl_rd);
  a_r11_wr_once: assert property (@(posedge clk) disable iff (!rst_n)
    ev_o.ctl_wr |=> !ev_o.ctl_wr);
  a_r11_fetch_once: assert property (@(posedge clk) disable iff (!rst_n)
    ev_o.fetch_vec |=> !ev_o.fetch_vec);

endmodule

// File: rtl/snap_state.sv
module snap_state
  import snap_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  bus_ev_t ev_i,
  input  logic    a7_i,
  input  logic    mode_bit_i,
  input  logic    press_i,
  output logic    paged_o,
  output logic    pend_o,
  output logic    hidden_o,
  output logic    allram_o
);
  logic paged_q, pend_q, hidden_q, allram_q;
  logic arm_ok;

  // a press is accepted only when idle and not in all-RAM mode
  assign arm_ok = press_i & ~pend_q & ~allram_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      paged_q  <= 1'b0;
      pend_q   <= 1'b0;
      hidden_q <= 1'b1;
      allram_q <= 1'b0;
    end else begin
      if (ev_i.fetch_vec && pend_q && !allram_q)
        paged_q <= 1'b1;
      else if (ev_i.ctl_rd)
        paged_q <= ~hidden_q & ~a7_i;

      // port write beats a simultaneous press
      if (ev_i.ctl_wr)
        pend_q <= 1'b0;
      else if (arm_ok)
        pend_q <= 1'b1;

      if (ev_i.hide_wr)
        hidden_q <= 1'b1;
      else if (arm_ok)
        hidden_q <= 1'b0;

      if (ev_i.mode_wr)
        allram_q <= mode_bit_i;
    end
  end

  assign paged_o  = paged_q;
  assign pend_o   = pend_q;
  assign hidden_o = hidden_q;
  assign allram_o = allram_q;

  a_r4_vector_pages_in: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_i.fetch_vec && pend_q && !allram_q) |=> paged_q);
  a_r5_hidden_pages_out: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_i.ctl_rd && hidden_q) |=> !paged_q);
  a_r6_clear_pending: assert property (@(posedge clk) disable iff (!rst_n)
    ev_i.ctl_wr |=> !pend_q);
  a_r6_hide: assert property (@(posedge clk) disable iff (!rst_n)
    ev_i.hide_wr |=> hidden_q);
  a_r7_mode_load: assert property (@(posedge clk) disable iff (!rst_n)
    ev_i.mode_wr |=> (allram_q == $past(mode_bit_i)));
  a_r8_pending_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q) |-> $past(press_i));

endmodule

// File: rtl/snap_pager_top.sv
module snap_pager_top
  import snap_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        mreq_n,
  input  logic        iorq_n,
  input  logic        rd_n,
  input  logic        wr_n,
  input  logic        m1_n,
  input  logic [15:0] addr,
  input  logic [7:0]  data,
  input  logic        button,
  output logic        nmi_n,
  output logic        rom_ce_n,
  output logic        ram_ce_n
);
  bus_ev_t ev;
  logic    a7, press;
  logic    paged, pend, hidden, allram;

  snap_btn_sync #(.SYNC_STAGES(2)) u_btn (
    .clk(clk), .rst_n(rst_n), .btn_i(button), .press_o(press)
  );

  snap_bus_decode u_dec (
    .clk(clk), .rst_n(rst_n), .mreq_n(mreq_n), .iorq_n(iorq_n),
    .rd_n(rd_n), .wr_n(wr_n), .m1_n(m1_n), .addr(addr),
    .ev_o(ev), .a7_o(a7)
  );

  snap_state u_st (
    .clk(clk), .rst_n(rst_n), .ev_i(ev), .a7_i(a7),
    .mode_bit_i(data[0]), .press_i(press),
    .paged_o(paged), .pend_o(pend), .hidden_o(hidden), .allram_o(allram)
  );

  assign nmi_n    = ~(pend & ~allram);
  assign rom_ce_n = ~(paged & ~mreq_n & in_window(addr, 1'b0));
  assign ram_ce_n = ~(paged & ~mreq_n & in_window(addr, 1'b1));

  a_r2_exclusive_ce: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rom_ce_n && !ram_ce_n));
  a_r2_ce_needs_mreq: assert property (@(posedge clk) disable iff (!rst_n)
    mreq_n |-> (rom_ce_n && ram_ce_n));
  a_r9_allram_mutes: assert property (@(posedge clk) disable iff (!rst_n)
    allram |-> nmi_n);
  a_r1_hidden_blocks_ce: assert property (@(posedge clk) disable iff (!rst_n)
    !paged |-> (rom_ce_n && ram_ce_n));

endmodule

// File: tb/snap_pager_tb.sv
module snap_pager_top_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic mreq_n = 1, iorq_n = 1, rd_n = 1, wr_n = 1, m1_n = 1;
  logic [15:0] addr = '0;
  logic [7:0]  data = '0;
  logic button = 0;
  logic nmi_n, rom_ce_n, ram_ce_n;
  int errors = 0, checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  snap_pager_top dut_i (
    .clk(clk), .rst_n(rst_n), .mreq_n(mreq_n), .iorq_n(iorq_n),
    .rd_n(rd_n), .wr_n(wr_n), .m1_n(m1_n), .addr(addr), .data(data),
    .button(button), .nmi_n(nmi_n), .rom_ce_n(rom_ce_n), .ram_ce_n(ram_ce_n)
  );

  // op codes: 1 io read, 2 io write, 3 opcode fetch, 5 button press
  // fields: op[29:26] addr[25:10] data[9:2] exp_nmi_n[1] exp_paged[0]
  localparam int NV = 23;
  localparam logic [29:0] VEC [NV] = '{
    {4'd1, 16'h003F, 8'h00, 1'b1, 1'b0},  // R5 hidden: no page-in
    {4'd5, 16'h0000, 8'h00, 1'b0, 1'b0},  // R8 R9 press arms
    {4'd5, 16'h0000, 8'h00, 1'b0, 1'b0},  // R8 second press ignored
    {4'd3, 16'h0066, 8'h00, 1'b0, 1'b1},  // R4 vector fetch pages in
    {4'd1, 16'h00BF, 8'h00, 1'b0, 1'b0},  // R5 A7=1 pages out
    {4'd1, 16'h013F, 8'h00, 1'b0, 1'b1},  // R5 A7=0 pages in
    {4'd2, 16'h00BF, 8'h00, 1'b1, 1'b1},  // R6 clear pending, no hide
    {4'd1, 16'h00BF, 8'h00, 1'b1, 1'b0},  // R5 not hidden: page out
    {4'd3, 16'h0066, 8'h00, 1'b1, 1'b0},  // R4 no pending: no page-in
    {4'd2, 16'h003F, 8'h00, 1'b1, 1'b0},  // R6 hide
    {4'd1, 16'h003F, 8'h00, 1'b1, 1'b0},  // R5 hidden stays out
    {4'd5, 16'h0000, 8'h00, 1'b0, 1'b0},  // R8 press unhides
    {4'd2, 16'h1FFD, 8'h01, 1'b1, 1'b0},  // R7 R9 all-RAM mutes
    {4'd3, 16'h0066, 8'h00, 1'b1, 1'b0},  // R4 all-RAM blocks fetch
    {4'd2, 16'h1FFD, 8'h00, 1'b0, 1'b0},  // R7 all-RAM cleared
    {4'd2, 16'h7FFD, 8'h01, 1'b0, 1'b0},  // R7 wrong nibble ignored
    {4'd3, 16'h0066, 8'h00, 1'b0, 1'b1},  // R4 fetch pages in
    {4'd1, 16'h003F, 8'h00, 1'b0, 1'b1},  // R5 stays in
    {4'd2, 16'h003F, 8'h00, 1'b1, 1'b1},  // R6 clear+hide, paging kept
    {4'd1, 16'h00BF, 8'h00, 1'b1, 1'b0},  // R5 hidden pages out
    {4'd2, 16'h1FFD, 8'h01, 1'b1, 1'b0},  // R7 all-RAM on
    {4'd5, 16'h0000, 8'h00, 1'b1, 1'b0},  // R8 press ignored in all-RAM
    {4'd2, 16'h1FFD, 8'h00, 1'b1, 1'b0}   // R8 still not pending
  };

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic idle_bus();
    mreq_n = 1; iorq_n = 1; rd_n = 1; wr_n = 1; m1_n = 1;
  endtask

  task automatic bus_op(input logic [3:0] op, input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; data = d;
    case (op)
      4'd1: begin iorq_n = 0; rd_n = 0; end
      4'd2: begin iorq_n = 0; wr_n = 0; end
      4'd3: begin mreq_n = 0; rd_n = 0; m1_n = 0; end
      4'd5: button = 1;
      default: ;
    endcase
    repeat (4) @(negedge clk);
    idle_bus(); button = 0;
    repeat (4) @(negedge clk);
  endtask

  // probe overlay via chip enables (plain read, no M1); R2 R3
  task automatic probe(input logic exp_paged, input string tag);
    @(negedge clk);
    addr = 16'h0000; #1 chk({"R2 idle ", tag}, rom_ce_n, 1'b1);
    mreq_n = 0; rd_n = 0;
    #1 chk({"R2 rom ", tag}, rom_ce_n, ~exp_paged);
    chk({"R3 rom-area ram ", tag}, ram_ce_n, 1'b1);
    addr = 16'h2000;
    #1 chk({"R3 ram ", tag}, ram_ce_n, ~exp_paged);
    chk({"R2 ram-area rom ", tag}, rom_ce_n, 1'b1);
    addr = 16'h4000;
    #1 chk({"R2 R3 above ", tag}, rom_ce_n & ram_ce_n, 1'b1);
    idle_bus();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 nmi", nmi_n, 1'b1);
    chk("R1 rom", rom_ce_n, 1'b1);
    chk("R1 ram", ram_ce_n, 1'b1);
    rst_n = 1;
    repeat (2) @(negedge clk);
    probe(1'b0, "R1 after reset");

    for (int i = 0; i < NV; i++) begin
      bus_op(VEC[i][29:26], VEC[i][25:10], VEC[i][9:2]);
      chk($sformatf("vec%0d R9 nmi", i), nmi_n, VEC[i][1]);
      probe(VEC[i][0], $sformatf("vec%0d", i));
    end

    // state: pending 0, hidden 1, all-RAM 0, paged out
    // R10: long hold gives one event; a clear during the hold stays clear
    @(negedge clk); button = 1;
    repeat (6) @(negedge clk);
    chk("R10 armed", nmi_n, 1'b0);
    @(negedge clk); addr = 16'h00BF; iorq_n = 0; wr_n = 0;
    @(negedge clk); idle_bus();
    repeat (20) @(negedge clk);
    chk("R10 no second event", nmi_n, 1'b1);
    button = 0;
    repeat (4) @(negedge clk);

    // R11: held read, address moves from A7=0 to A7=1 mid-access
    @(negedge clk); addr = 16'h003F; iorq_n = 0; rd_n = 0;
    repeat (2) @(negedge clk);
    addr = 16'h00BF;
    repeat (3) @(negedge clk);
    idle_bus();
    repeat (2) @(negedge clk);
    probe(1'b1, "R11 held read");

    // R1 again: reset mid-state
    rst_n = 0;
    @(negedge clk);
    chk("R1 nmi after reset", nmi_n, 1'b1);
    rst_n = 1;
    repeat (2) @(negedge clk);
    probe(1'b0, "R1 re-reset");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule